// File: doc/BRIEF.md
# Multi-Width Byte Transmit Queue with Drain Interrupt

This block is the transmit queue of a byte-serial output device. Software writes 1, 2 or 4 bytes at a time through three push registers. Each write is one atomic access. The queue holds up to 16 bytes. A downstream transmitter takes the bytes one at a time over a valid/ready handshake.

Software reads the current fill level at any time. An interrupt marks the moment the queue runs dry. The interrupt is raised only on the step from one byte left to none. A level that simply stays at zero does not raise it, and no threshold raises it either.

The register port is a simple single-cycle bus. A write to a push register is accepted whole or refused whole. A refused write sets a sticky overflow flag. The drain event sets a pending flag. That flag drives the interrupt pin through an enable bit.

Top module: `txq_top`

## Requirements
- R1: After reset the level reads 0, `out_valid` is low, `irq` is low, and the status and control registers read 0.
- R2: Writes to addresses 0, 1 and 2 enqueue 1, 2 and 4 bytes respectively, taken from the low bytes of `wr_data`.
- R3: A multi-byte write enqueues `wr_data[7:0]` first, then `[15:8]`, then `[23:16]`, then `[31:24]`. Bytes leave the queue in the order they entered.
- R4: A read of address 3 returns the number of queued bytes (0 to 16) in `rd_data[4:0]`. `rd_data` is registered at the edge that ends the read cycle and shows the level as it stood before that edge.
- R5: A push is accepted only if its byte count is no larger than 16 minus the level at the start of the cycle. Otherwise the push is dropped entirely, the level is unchanged, and status bit 1 (overflow) is set. The overflow bit stays set until a write of 1 to status bit 1 (address 4).
- R6: `out_valid` is high whenever the level is nonzero, and `out_data` is the oldest byte. A byte is removed only in a cycle where `out_valid` and `out_ready` are both high. Otherwise `out_data` holds.
- R7: Status bit 0 (pending) is set only at an edge where the level goes from 1 to 0. It is not set while the level stays at 0, and it is not set at any other level.
- R8: If the last byte is removed in the same cycle that a push is accepted, the level does not reach 0 and pending is not set.
- R9: Writing 1 to status bit 0 clears pending. A drain event in the same cycle takes priority over the clear.
- R10: `irq` is high exactly when pending is set and the enable bit (bit 0 of address 5, readable) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| out_valid | output | 1 | Head byte available |
| out_ready | input | 1 | Downstream accepts the head byte |
| out_data | output | 8 | Head byte |
| irq | output | 1 | Drain interrupt |

## Verification
A push driven in cycle t changes the level, `out_valid` and the head byte at the edge that ends cycle t. A handshake in cycle t removes its byte at that same edge. Pending and `irq` follow at the edge where the final byte leaves. A read returns its value one edge after the request.

The bench drives every input just after the falling edge. It samples outputs late in the low phase. Expected bytes enter the scoreboard only after the edge that accepts them, so the queue size always equals the level that the design should show at the sampling point. Register reads are compared after the edge that loads `rd_data`.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_PUSH1  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_PUSH2  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_PUSH4  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_LEVEL  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd5;

  localparam int unsigned ST_PEND = 0;
  localparam int unsigned ST_OVF  = 1;
  localparam int unsigned CT_EN   = 0;

  typedef struct packed {
    logic clr_pend;
    logic clr_ovf;
    logic en_we;
    logic en_val;
  } ctl_wr_t;
endpackage

// File: rtl/txq_reg_decode.sv
module txq_reg_decode
  import txq_pkg::*;
#(
  parameter int unsigned MAXB = 4,
  localparam int unsigned LW = $clog2(MAXB + 1)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic              push_req,
  output logic [LW-1:0]     push_len,
  output ctl_wr_t           ctl
);
  always_comb begin
    push_req = 1'b0;
    push_len = '0;
    ctl      = '0;
    if (wr_en) begin
      unique case (addr)
        RA_PUSH1: begin push_req = 1'b1; push_len = LW'(1); end
        RA_PUSH2: begin push_req = 1'b1; push_len = LW'(2); end
        RA_PUSH4: begin push_req = 1'b1; push_len = LW'(4); end
        RA_STATUS: begin
          ctl.clr_pend = wr_data[ST_PEND];
          ctl.clr_ovf  = wr_data[ST_OVF];
        end
        RA_CTRL: begin
          ctl.en_we  = 1'b1;
          ctl.en_val = wr_data[CT_EN];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txq_byte_ring.sv
module txq_byte_ring #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned MAXB  = 4,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned LW = $clog2(MAXB + 1),
  localparam int unsigned SW = $clog2(MAXB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [LW-1:0]     push_len,
  input  logic [8*MAXB-1:0] push_data,
  input  logic              pop_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic [CW-1:0]     level,
  output logic              accept,
  output logic              reject,
  output logic              drained
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] free_slots;
  logic          fits, pop;

  assign free_slots = CW'(DEPTH) - cnt;
  assign fits       = CW'(push_len) <= free_slots;
  assign accept     = push_req && fits;
  assign reject     = push_req && !fits;
  assign out_valid  = cnt != '0;
  assign pop        = out_valid && pop_ready;
  assign drained    = pop && (cnt == CW'(1)) && !accept;
  assign out_data   = mem[rptr];
  assign level      = cnt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PW-1:0] off;
    logic [SW-1:0] sel;
    logic          hit;
    assign off = PW'(i) - wptr;
    assign sel = off[SW-1:0];
    assign hit = accept && ({{(32-PW){1'b0}}, off} < {{(32-LW){1'b0}}, push_len});
    always_ff @(posedge clk) begin
      if (hit) mem[i] <= push_data[{sel, 3'b000} +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (accept) wptr <= wptr + PW'(push_len);
      if (pop)    rptr <= rptr + PW'(1);
      cnt <= cnt + (accept ? CW'(push_len) : CW'(0)) - (pop ? CW'(1) : CW'(0));
    end
  end
endmodule

// File: rtl/txq_irq_ctrl.sv
module txq_irq_ctrl
  import txq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    drained,
  input  logic    reject,
  input  ctl_wr_t ctl,
  output logic    pend,
  output logic    ovf,
  output logic    en,
  output logic    irq
);
  logic pend_nx, ovf_nx, en_nx;

  always_comb begin
    pend_nx = drained ? 1'b1 : (ctl.clr_pend ? 1'b0 : pend);
    ovf_nx  = reject  ? 1'b1 : (ctl.clr_ovf  ? 1'b0 : ovf);
    en_nx   = ctl.en_we ? ctl.en_val : en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      ovf  <= 1'b0;
      en   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_nx;
      ovf  <= ovf_nx;
      en   <= en_nx;
      irq  <= pend_nx && en_nx;
    end
  end
endmodule

// File: rtl/txq_top.sv
module txq_top
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned MAXB = BUS_W / 8,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned LW = $clog2(MAXB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              irq
);
  logic          push_req, accept, reject, drained;
  logic [LW-1:0] push_len;
  ctl_wr_t       ctl;
  logic [CW-1:0] level_q;
  logic          pend_q, ovf_q, en_q;

  txq_reg_decode #(.MAXB(MAXB)) u_dec (
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .push_req (push_req),
    .push_len (push_len),
    .ctl      (ctl)
  );

  txq_byte_ring #(.DEPTH(DEPTH), .MAXB(MAXB)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .push_len  (push_len),
    .push_data (wr_data),
    .pop_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .level     (level_q),
    .accept    (accept),
    .reject    (reject),
    .drained   (drained)
  );

  txq_irq_ctrl u_irq (
    .clk     (clk),
    .rst     (rst),
    .drained (drained),
    .reject  (reject),
    .ctl     (ctl),
    .pend    (pend_q),
    .ovf     (ovf_q),
    .en      (en_q),
    .irq     (irq)
  );

  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (addr)
      RA_LEVEL:  rd_mux = BUS_W'(level_q);
      RA_STATUS: begin
        rd_mux[ST_PEND] = pend_q;
        rd_mux[ST_OVF]  = ovf_q;
      end
      RA_CTRL:   rd_mux[CT_EN] = en_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  logic unused_accept;
  assign unused_accept = accept;
endmodule

// File: rtl/txq_top_chk.sv
module txq_top_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [31:0]   wr_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          irq,
  input logic [CW-1:0] level_q,
  input logic          pend_q
);
  logic          is_push;
  logic [CW-1:0] want;
  assign is_push = wr_en && (addr <= 3'd2);
  assign want    = (addr == 3'd0) ? CW'(1) : (addr == 3'd1) ? CW'(2) : CW'(4);

  p_level_cap_r4: assert property (@(posedge clk) disable iff (rst)
    level_q <= CW'(DEPTH));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_pop_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !is_push |=> level_q == $past(level_q) - CW'(1));

  p_no_partial_r5: assert property (@(posedge clk) disable iff (rst)
    is_push && (want > CW'(DEPTH) - level_q) |=> level_q <= $past(level_q));

  p_drain_edge_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(level_q) == CW'(1) && level_q == '0);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(wr_en && addr == 3'd4 && wr_data[0]));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> pend_q);
endmodule

bind txq_top txq_top_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .wr_data   (wr_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .irq       (irq),
  .level_q   (level_q),
  .pend_q    (pend_q)
);

// File: tb/txq_top_test.sv
module txq_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        out_valid, out_ready, irq;
  logic [7:0]  out_data;

  int  n_chk = 0, n_fail = 0;
  bit  auto_mode = 1'b0, man_ready = 1'b0, done = 1'b0;
  int  gap = 4, gcnt = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  txq_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slow consumer: one accepted byte per gap cycles in auto mode
  initial out_ready = 1'b0;
  always begin
    @(negedge clk); #1;
    if (auto_mode) begin
      out_ready = (gcnt == gap - 1);
      gcnt = (gcnt == gap - 1) ? 0 : gcnt + 1;
    end else out_ready = man_ready;
  end

  // scoreboard monitor
  always begin
    @(negedge clk); #8;
    if (!rst && !done) begin
      chk("R6 valid", {31'b0, out_valid}, {31'b0, exp_q.size() != 0});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("R3 unexpected byte", {24'b0, out_data}, 32'hFFFF);
        else chk("R3 byte order", {24'b0, out_data}, {24'b0, exp_q.pop_front()});
      end
    end
  end

  task automatic push(input logic [2:0] a, input logic [31:0] d);
    int n;
    bit ok;
    n = (a == 3'd0) ? 1 : (a == 3'd1) ? 2 : 4;
    @(negedge clk);
    ok = (n <= 16 - exp_q.size());
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (ok) for (int k = 0; k < n; k++) exp_q.push_back(d[8*k +: 8]);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pop_one();
    @(negedge clk); man_ready = 1'b1;
    @(negedge clk); man_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);
    #8;
    chk("R1 valid", {31'b0, out_valid}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(3'd3, v); chk("R1 level", v, 0);
    rd(3'd4, v); chk("R1 status", v, 0);
    rd(3'd5, v); chk("R1 ctrl", v, 0);

    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R10 enable readback", v, 1);

    // R2 pushes of each width, consumer stalled
    push(3'd2, 32'h44332211);
    push(3'd1, 32'hDEAD6655);
    push(3'd0, 32'hFFFFFF77);
    rd(3'd3, v); chk("R2 R4 level after 1+2+4", v, 7);
    #8; chk("R6 head byte", {24'b0, out_data}, 32'h11);

    // R3 slow drain through the scoreboard
    gap = 4; gcnt = 0; auto_mode = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    idle(2);
    #8; chk("R10 irq after drain", {31'b0, irq}, 1);
    rd(3'd4, v); chk("R7 pending after drain", v, 1);
    auto_mode = 1'b0;

    // R9 clear, then R7 no set while level stays zero
    wr(3'd4, 32'h1);
    #8; chk("R9 irq cleared", {31'b0, irq}, 0);
    idle(10);
    rd(3'd4, v); chk("R7 idle empty no pending", v, 0);

    // R5 overflow, whole write dropped
    push(3'd2, 32'h0D0C0B0A);
    push(3'd2, 32'h1D1C1B1A);
    push(3'd2, 32'h2D2C2B2A);
    push(3'd1, 32'h00003B3A);
    push(3'd2, 32'h4D4C4B4A);
    rd(3'd3, v); chk("R5 level unchanged at 14", v, 14);
    rd(3'd4, v); chk("R5 overflow set", v, 2);
    push(3'd1, 32'h00005B5A);
    rd(3'd3, v); chk("R5 exact fit to 16", v, 16);
    push(3'd0, 32'h000000EE);
    rd(3'd3, v); chk("R4 R5 level stays 16", v, 16);
    wr(3'd4, 32'h2);
    rd(3'd4, v); chk("R5 overflow cleared", v, 0);

    // R7 no event at intermediate levels
    for (int k = 0; k < 15; k++) pop_one();
    rd(3'd3, v); chk("R4 level 1", v, 1);
    rd(3'd4, v); chk("R7 no pending above zero", v, 0);
    #8; chk("R7 irq low above zero", {31'b0, irq}, 0);

    // R8 last pop coincides with a push
    @(negedge clk);
    man_ready = 1'b1;
    wr_en = 1'b1; addr = 3'd0; wr_data = 32'h3C;
    @(negedge clk);
    man_ready = 1'b0; wr_en = 1'b0;
    exp_q.push_back(8'h3C);
    rd(3'd3, v); chk("R8 level stays 1", v, 1);
    rd(3'd4, v); chk("R8 no pending", v, 0);
    pop_one();
    rd(3'd4, v); chk("R7 pending on 1 to 0", v, 1);

    // R10 gating by enable
    wr(3'd5, 32'h0);
    #8; chk("R10 irq masked", {31'b0, irq}, 0);
    wr(3'd5, 32'h1);
    #8; chk("R10 irq unmasked", {31'b0, irq}, 1);
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R9 pending cleared", v, 0);
    idle(2);
    finish_run();
  end
endmodule